// File: doc/BRIEF.md
# Command-Driven Flash Data Memory Controller

This block fronts a 4 KB nonvolatile data array that is split into 1024 pages of four bytes. A processor reaches the array only through a small register port. That port holds four data bytes, a low and a high address byte, and a command/status byte. Writing an opcode into the command byte starts one operation. The operations are:
- read, program, verify or erase a whole page;
- erase the whole array;
- read or program a single byte.

The array behaves like flash. Erasing sets bytes to FFh, and programming can only clear bits, so software must erase a location before it writes new data there.

Every accepted command holds a busy flag for a fixed number of cycles, and a full erase holds it longer. While the flag is up, the block drops register writes. A mode flag selects a normal mode or an upload mode. In upload mode, only the two mode-switch commands are honoured. Every other command reports an error status and leaves both the array and the data registers alone.

The register port is a plain strobe interface with no back-pressure: a write presented while `busy` is high is discarded, not stalled. Software polls `busy` (or simply waits) before issuing the next write. Register reads are combinational on `reg_sel`.

Top module: `fdm_ctrl`

## Requirements
- R1: After reset, all four data bytes, both address bytes and the status byte read 00h, `busy` is 0 and `upload_mode` is 0. Register select codes are: 0 to 3 for data bytes 0 to 3, 4 for the low address byte, 5 for the high address byte, and 6 for command (write) and status (read).
- R2: Opcode 01h copies byte lane i of the addressed page into data byte i, for i = 0 to 3. Lane i is byte address page*4+i.
- R3: Opcode 02h programs the addressed page. Each stored byte becomes its old value ANDed with the matching data byte.
- R4: Opcode 04h compares the four data bytes with the addressed page. The status byte then reads 00h on a match and 01h on a mismatch, and the array is not changed.
- R5: Opcode 05h sets the four bytes of the addressed page to FFh and leaves every other page unchanged.
- R6: Opcode 06h sets every byte of the array to FFh, one page per cycle. `busy` stays high for exactly one cycle per page (1024 cycles by default).
- R7: Opcode 81h loads the byte at the 12-bit byte address into data byte 0 and leaves data bytes 1 to 3 unchanged.
- R8: Opcode 82h ANDs data byte 0 into the byte at the 12-bit byte address and leaves the other three bytes of that page unchanged.
- R9: Opcode F0h sets `upload_mode`, and opcode 0Fh clears it. Both give status 00h. In upload mode, any other opcode gives status FFh and changes neither the array nor the data bytes.
- R10: Opcode 03h and any opcode not listed above give status FFh and leave the array unchanged. A command that succeeds gives status 00h, apart from a verify mismatch.
- R11: After an accepted command write, `busy` is high for BUSY_CYCLES cycles (4 by default). Register writes made while `busy` is high have no effect.
- R12: The combined address is {high, low}. Page commands use its low 10 bits as the page index, byte commands use its low 12 bits, and higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Write data or opcode |
| reg_rdata | output | 8 | Read data of the selected register |
| busy | output | 1 | Command in progress; writes are dropped |
| upload_mode | output | 1 | 1 while in upload mode |

## Verification
Programming is exercised three ways:
- onto erased cells, which shows that the pattern is stored;
- onto already-programmed cells with a pattern that overlaps them, which separates AND semantics from overwrite;
- through the byte path, which shows that only one lane changes.

Verify is run once with deliberately different data and once straight after a page read, which separates the match status from the mismatch status. Addresses carrying junk high bits alias onto a known page, showing that those bits are ignored. An erase of one page checks that its neighbours keep their contents. Commands given in upload mode, and reserved opcodes, are followed by reads of the data registers and the page they target.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam logic [7:0] OP_PG_READ   = 8'h01;
  localparam logic [7:0] OP_PG_PROG   = 8'h02;
  localparam logic [7:0] OP_PG_VERIFY = 8'h04;
  localparam logic [7:0] OP_PG_ERASE  = 8'h05;
  localparam logic [7:0] OP_ALL_ERASE = 8'h06;
  localparam logic [7:0] OP_BYTE_READ = 8'h81;
  localparam logic [7:0] OP_BYTE_PROG = 8'h82;
  localparam logic [7:0] OP_TO_NORMAL = 8'h0F;
  localparam logic [7:0] OP_TO_UPLOAD = 8'hF0;

  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_MISMATCH = 8'h01;
  localparam logic [7:0] ST_ERROR    = 8'hFF;

  localparam logic [2:0] SEL_ADDR_LO = 3'd4;
  localparam logic [2:0] SEL_ADDR_HI = 3'd5;
  localparam logic [2:0] SEL_CMD     = 3'd6;

  localparam int LANES = 4;
  typedef logic [LANES-1:0][7:0] page_word_t;
endpackage

// File: rtl/fdm_array.sv
module fdm_array #(
  parameter int PAGES = 1024,
  localparam int IDX_W = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  fdm_pkg::page_word_t wr_word,
  input  logic [IDX_W-1:0]   rd_idx,
  output fdm_pkg::page_word_t rd_word
);
  fdm_pkg::page_word_t mem [PAGES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/fdm_sweep.sv
module fdm_sweep #(
  parameter int PAGES = 1024,
  localparam int IDX_W = $clog2(PAGES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAGES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/fdm_busy.sv
module fdm_busy #(
  parameter int CYCLES = 4,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/fdm_ctrl.sv
module fdm_ctrl #(
  parameter int PAGES       = 1024,
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       upload_mode
);
  import fdm_pkg::*;

  localparam int IDX_W   = $clog2(PAGES);
  localparam int BADDR_W = IDX_W + 2;

  page_word_t data_q;
  logic [7:0] addr_lo_q, addr_hi_q, status_q;
  logic       upload_q;

  logic               accept, cmd_go, timer_busy, wipe_active;
  logic [IDX_W-1:0]   wipe_idx;
  logic [15:0]        addr16;
  logic [IDX_W-1:0]   page_idx, byte_page, rd_idx;
  logic [1:0]         lane;
  page_word_t         rd_word, cmd_word, arr_word;
  logic               arr_we;

  logic               is_byte_op, op_write, op_ld_page, op_ld_byte, op_wipe, nxt_upload;
  logic [7:0]         nxt_status;

  assign accept = reg_wr && !busy;
  assign cmd_go = accept && (reg_sel == SEL_CMD);

  // Address decode: upper bits beyond the array are dropped.
  assign addr16    = {addr_hi_q, addr_lo_q};
  assign page_idx  = addr16[IDX_W-1:0];
  assign byte_page = addr16[BADDR_W-1:2];
  assign lane      = addr16[1:0];

  assign is_byte_op = (reg_wdata == OP_BYTE_READ) || (reg_wdata == OP_BYTE_PROG);
  assign rd_idx     = is_byte_op ? byte_page : page_idx;

  // Opcode decode
  always_comb begin
    op_write   = 1'b0;
    op_ld_page = 1'b0;
    op_ld_byte = 1'b0;
    op_wipe    = 1'b0;
    cmd_word   = rd_word;
    nxt_status = ST_OK;
    nxt_upload = upload_q;
    if (upload_q) begin
      if (reg_wdata == OP_TO_NORMAL)      nxt_upload = 1'b0;
      else if (reg_wdata != OP_TO_UPLOAD) nxt_status = ST_ERROR;
    end else begin
      case (reg_wdata)
        OP_PG_READ:   op_ld_page = 1'b1;
        OP_PG_PROG: begin
          op_write = 1'b1;
          cmd_word = rd_word & data_q;
        end
        OP_PG_VERIFY: nxt_status = (rd_word == data_q) ? ST_OK : ST_MISMATCH;
        OP_PG_ERASE: begin
          op_write = 1'b1;
          cmd_word = '1;
        end
        OP_ALL_ERASE: op_wipe = 1'b1;
        OP_BYTE_READ: op_ld_byte = 1'b1;
        OP_BYTE_PROG: begin
          op_write       = 1'b1;
          cmd_word[lane] = rd_word[lane] & data_q[0];
        end
        OP_TO_UPLOAD: nxt_upload = 1'b1;
        OP_TO_NORMAL: nxt_upload = 1'b0;
        default:      nxt_status = ST_ERROR;
      endcase
    end
  end

  // Register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      status_q  <= ST_OK;
      upload_q  <= 1'b0;
    end else if (accept) begin
      case (reg_sel)
        3'd0, 3'd1, 3'd2, 3'd3: data_q[reg_sel[1:0]] <= reg_wdata;
        SEL_ADDR_LO: addr_lo_q <= reg_wdata;
        SEL_ADDR_HI: addr_hi_q <= reg_wdata;
        SEL_CMD: begin
          status_q <= nxt_status;
          upload_q <= nxt_upload;
          if (op_ld_page) data_q    <= rd_word;
          if (op_ld_byte) data_q[0] <= rd_word[lane];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = data_q[reg_sel[1:0]];
      SEL_ADDR_LO: reg_rdata = addr_lo_q;
      SEL_ADDR_HI: reg_rdata = addr_hi_q;
      SEL_CMD:     reg_rdata = status_q;
      default:     reg_rdata = 8'h00;
    endcase
  end

  // Array write port: sweep has priority (commands are blocked while it runs)
  assign arr_we   = wipe_active || (cmd_go && op_write);
  assign arr_word = wipe_active ? '1 : cmd_word;

  fdm_array #(.PAGES(PAGES)) u_array (
    .clk     (clk),
    .wr_en   (arr_we),
    .wr_idx  (wipe_active ? wipe_idx : rd_idx),
    .wr_word (arr_word),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  fdm_sweep #(.PAGES(PAGES)) u_sweep (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cmd_go && op_wipe),
    .active (wipe_active),
    .idx    (wipe_idx)
  );

  fdm_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_go),
    .busy  (timer_busy)
  );

  assign busy        = timer_busy || wipe_active;
  assign upload_mode = upload_q;
endmodule

// File: rtl/fdm_ctrl_chk.sv
module fdm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       upload_mode,
  input logic [7:0] status_q,
  input logic [7:0] addr_lo_q,
  input logic       wipe_active
);
  logic cmd_acc;
  assign cmd_acc = reg_wr && !busy && (reg_sel == 3'd6);

  // R11
  p_busy_after_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> busy);

  // R11
  p_drop_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy && reg_sel == 3'd4) |=> $stable(addr_lo_q));

  // R9
  p_enter_upload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && reg_wdata == 8'hF0) |=> upload_mode);

  // R9
  p_leave_upload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && reg_wdata == 8'h0F) |=> !upload_mode);

  // R9
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_acc |=> $stable(upload_mode));

  // R10
  p_reserved_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && reg_wdata == 8'h03) |=> status_q == 8'hFF);

  // R6
  p_sweep_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && !upload_mode && reg_wdata == 8'h06) |=> wipe_active);
endmodule

bind fdm_ctrl fdm_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .busy        (busy),
  .upload_mode (upload_mode),
  .status_q    (status_q),
  .addr_lo_q   (addr_lo_q),
  .wipe_active (wipe_active)
);

// File: tb/test_fdm_ctrl.sv
module test_fdm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       busy, upload_mode;
  logic       rd_req = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  fdm_ctrl #(.PAGES(1024), .BUSY_CYCLES(4)) i_fdm_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .upload_mode(upload_mode)
  );

  // Monitor: pops expected read values and compares
  always @(negedge clk) begin
    if (rd_req && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", t, reg_rdata, e);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    wr(3'd6, op);
    wait_idle();
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    wr(3'd5, hi);
    wr(3'd4, lo);
  endtask

  task automatic set_data(input logic [7:0] b0, b1, b2, b3);
    wr(3'd0, b0); wr(3'd1, b1); wr(3'd2, b2); wr(3'd3, b3);
  endtask

  task automatic expect_rd(input logic [2:0] s, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    reg_sel = s; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic expect_data(input logic [7:0] b0, b1, b2, b3, input string t);
    expect_rd(3'd0, b0, t); expect_rd(3'd1, b1, t);
    expect_rd(3'd2, b2, t); expect_rd(3'd3, b3, t);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 7; i++) expect_rd(3'(i), 8'h00, "R1 reset register");
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 mode after reset", int'(upload_mode), 0);

    // R6 erase all, busy one cycle per page
    wr(3'd6, 8'h06);
    n = 0;
    while (busy) begin n++; @(posedge clk); #1; end
    chk("R6 erase-all busy cycles", n, 1024);
    set_addr(8'h00, 8'h05);
    cmd(8'h01);
    expect_data(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R6 page erased");

    // R2/R3 program then read back on erased page
    set_data(8'hA5, 8'h3C, 8'h0F, 8'hF0);
    cmd(8'h02);
    set_data(8'h00, 8'h00, 8'h00, 8'h00);
    cmd(8'h01);
    expect_data(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R2 page read lanes");

    // R3 AND semantics on reprogram
    set_data(8'hF0, 8'hFF, 8'h33, 8'hFF);
    cmd(8'h02);
    // R4 mismatch
    cmd(8'h04);
    expect_rd(3'd6, 8'h01, "R4 verify mismatch");
    cmd(8'h01);
    expect_data(8'hA0, 8'h3C, 8'h03, 8'hF0, "R3 programming ANDs");
    cmd(8'h04);
    expect_rd(3'd6, 8'h00, "R4 verify match");

    // R7 byte read: byte 0x015 = page 5 lane 1
    set_data(8'h00, 8'h99, 8'h03, 8'hF0);
    set_addr(8'h00, 8'h15);
    cmd(8'h81);
    expect_data(8'h3C, 8'h99, 8'h03, 8'hF0, "R7 byte read into data 0");

    // R8 byte program: byte 0x016 (03) & 0C = 00
    wr(3'd0, 8'h0C);
    set_addr(8'h00, 8'h16);
    cmd(8'h82);
    set_addr(8'h00, 8'h05);
    cmd(8'h01);
    expect_data(8'hA0, 8'h3C, 8'h00, 8'hF0, "R8 byte program one lane");
    set_addr(8'h00, 8'h04);
    cmd(8'h01);
    expect_data(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R8 neighbour page untouched");

    // R5 page erase keeps neighbours
    set_addr(8'h00, 8'h06);
    set_data(8'h11, 8'h22, 8'h33, 8'h44);
    cmd(8'h02);
    set_addr(8'h00, 8'h05);
    cmd(8'h05);
    cmd(8'h01);
    expect_data(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5 page erased");
    set_addr(8'h00, 8'h06);
    cmd(8'h01);
    expect_data(8'h11, 8'h22, 8'h33, 8'h44, "R5 neighbour kept");

    // R12 high address bits ignored
    set_data(8'h00, 8'h00, 8'h00, 8'h00);
    set_addr(8'hF4, 8'h06);
    cmd(8'h01);
    expect_data(8'h11, 8'h22, 8'h33, 8'h44, "R12 page alias");
    set_addr(8'hF0, 8'h19);
    cmd(8'h81);
    expect_rd(3'd0, 8'h22, "R12 byte alias");

    // R10 reserved and undefined codes
    cmd(8'h03);
    expect_rd(3'd6, 8'hFF, "R10 reserved 03");
    cmd(8'h7E);
    expect_rd(3'd6, 8'hFF, "R10 undefined 7E");
    set_addr(8'h00, 8'h06);
    set_data(8'h00, 8'h00, 8'h00, 8'h00);
    cmd(8'h01);
    expect_data(8'h11, 8'h22, 8'h33, 8'h44, "R10 array unchanged");
    expect_rd(3'd6, 8'h00, "R10 success status");

    // R9 upload mode
    set_data(8'h00, 8'h00, 8'h00, 8'h00);
    cmd(8'hF0);
    chk("R9 upload entered", int'(upload_mode), 1);
    expect_rd(3'd6, 8'h00, "R9 mode switch status");
    cmd(8'h01);
    expect_rd(3'd6, 8'hFF, "R9 read in upload errors");
    expect_data(8'h00, 8'h00, 8'h00, 8'h00, "R9 data untouched in upload");
    cmd(8'h05);
    expect_rd(3'd6, 8'hFF, "R9 erase in upload errors");
    cmd(8'h0F);
    chk("R9 normal restored", int'(upload_mode), 0);
    expect_rd(3'd6, 8'h00, "R9 return status");
    cmd(8'h01);
    expect_data(8'h11, 8'h22, 8'h33, 8'h44, "R9 array untouched in upload");

    // R11 busy length and dropped writes
    wr(3'd6, 8'h0F);
    n = 0;
    while (busy) begin n++; @(posedge clk); #1; end
    chk("R11 busy cycles", n, 4);
    wr(3'd6, 8'h0F);
    wr(3'd4, 8'h55);
    wait_idle();
    expect_rd(3'd4, 8'h06, "R11 write dropped while busy");

    report();
  end
endmodule